// File: doc/BRIEF.md
# Prescaled Channel Timeout Monitor

This block watches one sequencing channel and flags it as hung when the channel stays busy for too long without making progress. A free-running prescaler divides the core clock by a selectable power of two. The resulting ticks are counted while the channel is busy. When the count reaches a selectable power-of-two limit, the monitor sets a sticky timeout status bit and emits a single-cycle abort pulse to the channel.

Any progress indication from the channel restarts the count, such as the completion of one work item. So does the channel dropping its busy signal. Software clears the status with a write-one-to-clear pulse. Setting the prescaler code to zero switches the whole monitor off: the prescaler holds its value and the tick counter does not advance.

The divider step is a parameter. The default divides by 2^8, 2^16 or 2^24 for codes 1, 2 and 3. The limit is 2^(BASE_LOG + code) ticks, which gives 4 to 512 ticks with the default base of 2.

Top module: `tmo_monitor`

## Requirements
- R1: With `prescale_sel` = 0 no tick is produced, the tick counter holds its value and the prescaler counter does not advance, so no timeout can occur.
- R2: For `prescale_sel` = s (1..3) the prescaler is a free-running counter of 3·SHIFT_UNIT bits that starts at 0 after reset and advances once per clock. A tick is taken on each clock edge at which its low s·SHIFT_UNIT bits are all ones, which gives one tick every 2^(s·SHIFT_UNIT) clocks.
- R3: For `limit_sel` = c (0..7) the timeout limit is 2^(BASE_LOG+c) ticks: 4, 8, 16, 32, 64, 128, 256 or 512 with the default base.
- R4: `timeout_status` and `abort_pulse` go high in the cycle after the clock edge at which the limit-th tick is counted. Counting starts from zero at the first edge with `chan_busy` high and `chan_progress` low.
- R5: `abort_pulse` is high for exactly one clock per timeout, and no further abort occurs while `timeout_status` is set.
- R6: `timeout_status` stays set until a clock edge with `status_clr` high clears it. `chan_busy` going low does not clear it.
- R7: A clock edge with `chan_progress` high clears the tick count, so the next timeout needs a full limit of ticks counted from the following edge.
- R8: A clock edge with `chan_busy` low clears the tick count, and no tick is counted while the channel is idle.
- R9: After reset `timeout_status` and `abort_pulse` are low and the prescaler counter is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| arst_n | input | 1 | Asynchronous active-low reset |
| prescale_sel | input | 2 | Prescaler code: 0 off, s divides by 2^(s·SHIFT_UNIT) |
| limit_sel | input | 3 | Timeout limit code c: 2^(BASE_LOG+c) ticks |
| chan_busy | input | 1 | Channel is executing |
| chan_progress | input | 1 | Channel finished a work item this cycle |
| status_clr | input | 1 | Write-one-to-clear pulse for the status bit |
| timeout_status | output | 1 | Sticky timeout flag |
| abort_pulse | output | 1 | One-cycle request to abort the channel |

## Verification
The bench builds the monitor with SHIFT_UNIT = 2, so the three prescaler codes divide by 4, 16 and 64 and the prescaler is only 6 bits wide. This reduction makes every limit code reachable for prescaler codes 1 and 2, and codes 0 to 5 reachable for code 3, within tens of thousands of cycles. The exact abort cycle is then predicted from a bench-side prescaler phase and compared with the cycle the pulse is seen. With the short periods, the runs that exercise the disable, idle and progress restarts can also check the following timeout to the cycle.

// File: rtl/tmo_pkg.sv
package tmo_pkg;

  // log2 of the tick period for a prescaler code
  function automatic int unsigned tick_period_log(input logic [1:0] sel,
                                                  input int unsigned unit);
    return 32'(sel) * unit;
  endfunction

  // log2 of the timeout limit in ticks for a limit code
  function automatic int unsigned limit_log(input logic [2:0] code,
                                            input int unsigned base);
    return base + 32'(code);
  endfunction

endpackage

// File: rtl/tmo_prescaler.sv
module tmo_prescaler #(
  parameter int unsigned SHIFT_UNIT = 8,
  parameter int unsigned SEL_W      = 2,
  localparam int unsigned PRE_W     = SHIFT_UNIT * ((1 << SEL_W) - 1)
) (
  input  logic             clk,
  input  logic             arst_n,
  input  logic [SEL_W-1:0] sel,
  output logic             tick
);
  import tmo_pkg::*;

  logic [PRE_W-1:0] pre_q;
  logic [PRE_W-1:0] mask;
  logic             enabled;

  assign enabled = (sel != '0);

  always_comb begin
    mask = ~({PRE_W{1'b1}} << tick_period_log(sel, SHIFT_UNIT));
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n)      pre_q <= '0;
    else if (enabled) pre_q <= pre_q + 1'b1;
  end

  assign tick = enabled && ((pre_q & mask) == mask);

endmodule

// File: rtl/tmo_tick_counter.sv
module tmo_tick_counter #(
  parameter int unsigned TSEL_W   = 3,
  parameter int unsigned BASE_LOG = 2,
  localparam int unsigned CNT_W   = BASE_LOG + (1 << TSEL_W)
) (
  input  logic              clk,
  input  logic              arst_n,
  input  logic [TSEL_W-1:0] limit_sel,
  input  logic              busy,
  input  logic              progress,
  input  logic              tick,
  input  logic              halted,
  output logic              hit
);
  import tmo_pkg::*;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_inc;
  logic [CNT_W-1:0] limit;
  logic             counting;

  assign limit    = CNT_W'(1) << limit_log(limit_sel, BASE_LOG);
  assign cnt_inc  = cnt_q + 1'b1;
  assign counting = busy && !progress && tick && !halted;
  assign hit      = counting && (cnt_inc >= limit);

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n)                cnt_q <= '0;
    else if (!busy || progress) cnt_q <= '0;
    else if (hit)               cnt_q <= '0;
    else if (counting)          cnt_q <= cnt_inc;
  end

endmodule

// File: rtl/tmo_status.sv
module tmo_status (
  input  logic clk,
  input  logic arst_n,
  input  logic hit,
  input  logic clr,
  output logic status,
  output logic abort
);

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      status <= 1'b0;
      abort  <= 1'b0;
    end else begin
      abort <= hit;
      if (hit)      status <= 1'b1;
      else if (clr) status <= 1'b0;
    end
  end

endmodule

// File: rtl/tmo_monitor.sv
module tmo_monitor #(
  parameter int unsigned SHIFT_UNIT = 8,
  parameter int unsigned BASE_LOG   = 2
) (
  input  logic       clk,
  input  logic       arst_n,
  input  logic [1:0] prescale_sel,
  input  logic [2:0] limit_sel,
  input  logic       chan_busy,
  input  logic       chan_progress,
  input  logic       status_clr,
  output logic       timeout_status,
  output logic       abort_pulse
);

  logic tick_w;
  logic hit_w;

  tmo_prescaler #(.SHIFT_UNIT(SHIFT_UNIT), .SEL_W(2)) u_pre (
    .clk    (clk),
    .arst_n (arst_n),
    .sel    (prescale_sel),
    .tick   (tick_w)
  );

  tmo_tick_counter #(.TSEL_W(3), .BASE_LOG(BASE_LOG)) u_cnt (
    .clk       (clk),
    .arst_n    (arst_n),
    .limit_sel (limit_sel),
    .busy      (chan_busy),
    .progress  (chan_progress),
    .tick      (tick_w),
    .halted    (timeout_status),
    .hit       (hit_w)
  );

  tmo_status u_stat (
    .clk    (clk),
    .arst_n (arst_n),
    .hit    (hit_w),
    .clr    (status_clr),
    .status (timeout_status),
    .abort  (abort_pulse)
  );

endmodule

// File: rtl/tmo_monitor_chk.sv
module tmo_monitor_chk #(
  parameter int unsigned SHIFT_UNIT = 8
) (
  input logic       clk,
  input logic       arst_n,
  input logic [1:0] psel,
  input logic       busy,
  input logic       progress,
  input logic       clr,
  input logic       status,
  input logic       abort,
  input logic       tick
);
  localparam int unsigned GAP_W = SHIFT_UNIT * 3 + 1;

  logic [1:0]       psel_d;
  logic [GAP_W-1:0] gap_q;
  logic             seen_q;
  logic [GAP_W-1:0] period_m1;

  assign period_m1 = (GAP_W'(1) << (32'(psel) * SHIFT_UNIT)) - 1'b1;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      psel_d <= '0;
      gap_q  <= '0;
      seen_q <= 1'b0;
    end else begin
      psel_d <= psel;
      if (psel != psel_d || psel == '0) begin
        gap_q  <= '0;
        seen_q <= 1'b0;
      end else if (tick) begin
        gap_q  <= '0;
        seen_q <= 1'b1;
      end else begin
        gap_q <= gap_q + 1'b1;
      end
    end
  end

  // R1
  off_no_tick_chk: assert property (@(posedge clk) disable iff (!arst_n)
    (psel == 2'd0) |-> !tick);

  // R2
  tick_spacing_chk: assert property (@(posedge clk) disable iff (!arst_n)
    (tick && seen_q && psel == psel_d) |-> (gap_q == period_m1));

  // R4
  status_with_abort_chk: assert property (@(posedge clk) disable iff (!arst_n)
    $rose(status) |-> abort);

  // R5
  abort_single_chk: assert property (@(posedge clk) disable iff (!arst_n)
    abort |=> !abort);

  // R6
  status_sticky_chk: assert property (@(posedge clk) disable iff (!arst_n)
    (status && !clr) |=> status);

  // R7
  progress_no_abort_chk: assert property (@(posedge clk) disable iff (!arst_n)
    progress |=> !abort);

  // R8
  idle_no_abort_chk: assert property (@(posedge clk) disable iff (!arst_n)
    !busy |=> !abort);

endmodule

bind tmo_monitor tmo_monitor_chk #(.SHIFT_UNIT(SHIFT_UNIT)) u_chk (
  .clk      (clk),
  .arst_n   (arst_n),
  .psel     (prescale_sel),
  .busy     (chan_busy),
  .progress (chan_progress),
  .clr      (status_clr),
  .status   (timeout_status),
  .abort    (abort_pulse),
  .tick     (tick_w)
);

// File: tb/tb_tmo_monitor.sv
module tb_tmo_monitor;
  localparam int SU  = 2;
  localparam int BL  = 2;
  localparam int PMOD = 1 << (3 * SU);

  logic       clk = 1'b0;
  logic       arst_n = 1'b0;
  logic [1:0] prescale_sel = 2'd0;
  logic [2:0] limit_sel = 3'd0;
  logic       chan_busy = 1'b0;
  logic       chan_progress = 1'b0;
  logic       status_clr = 1'b0;
  logic       timeout_status;
  logic       abort_pulse;

  int n_vec = 0;
  int n_bad = 0;
  int pre_model = 0;
  bit done = 0;

  always #5 clk = ~clk;

  tmo_monitor #(.SHIFT_UNIT(SU), .BASE_LOG(BL)) dut (
    .clk(clk), .arst_n(arst_n), .prescale_sel(prescale_sel),
    .limit_sel(limit_sel), .chan_busy(chan_busy),
    .chan_progress(chan_progress), .status_clr(status_clr),
    .timeout_status(timeout_status), .abort_pulse(abort_pulse)
  );

  // bench-side prescaler phase: advances on every edge with a nonzero code
  always @(posedge clk or negedge arst_n) begin
    if (!arst_n) pre_model <= 0;
    else if (prescale_sel != 2'd0) pre_model <= (pre_model + 1) % PMOD;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // busy from the next edge with a cleared count; predict the abort edge
  task automatic run_case(input int ps, input int ts, input string req);
    int p, d, lim, off, k, first, pulses;
    @(negedge clk);
    prescale_sel = 2'(ps);
    limit_sel = 3'(ts);
    chan_busy = 1'b1;
    chan_progress = 1'b0;
    p = pre_model;
    d = 1 << (SU * ps);
    lim = 1 << (BL + ts);
    off = (d - 1 - (p % d)) % d;
    k = off + (lim - 1) * d;
    first = -1;
    pulses = 0;
    for (int i = 0; i < k + 2 * d + 4; i++) begin
      @(negedge clk);
      if (abort_pulse) begin
        pulses++;
        if (first < 0) first = i;
      end
    end
    check(first == k, {req, " R4 abort edge"}, first, k);
    check(pulses == 1, "R5 one abort pulse", pulses, 1);
    check(timeout_status == 1'b1, "R4 status set", int'(timeout_status), 1);
    chan_busy = 1'b0;
    repeat (4) @(negedge clk);
    check(timeout_status == 1'b1, "R6 status sticky while idle", int'(timeout_status), 1);
    status_clr = 1'b1;
    @(negedge clk);
    status_clr = 1'b0;
    check(timeout_status == 1'b0, "R6 status cleared", int'(timeout_status), 0);
  endtask

  task automatic count_aborts(input int cycles, output int n);
    n = 0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      if (abort_pulse || timeout_status) n++;
    end
  endtask

  initial begin
    int n;
    repeat (3) @(negedge clk);
    arst_n = 1'b1;
    @(negedge clk);
    // R9 reset state
    check(timeout_status == 1'b0, "R9 status after reset", int'(timeout_status), 0);
    check(abort_pulse == 1'b0, "R9 abort after reset", int'(abort_pulse), 0);
    check(pre_model == 0, "R9 prescaler held at 0 while off", pre_model, 0);

    // R1: disabled monitor never times out, prescaler holds
    chan_busy = 1'b1;
    limit_sel = 3'd0;
    count_aborts(300, n);
    check(n == 0, "R1 no timeout when prescaler off", n, 0);
    run_case(1, 0, "R1 restart after off");

    // R2 / R3 sweep
    for (int ps = 1; ps <= 3; ps++) begin
      for (int ts = 0; ts <= 7; ts++) begin
        if (!(ps == 3 && ts > 5)) run_case(ps, ts, (ps == 1) ? "R3 limit sweep" : "R2 divider sweep");
      end
    end

    // R8: idle keeps the count at zero
    @(negedge clk);
    prescale_sel = 2'd1;
    limit_sel = 3'd0;
    chan_busy = 1'b0;
    count_aborts(200, n);
    check(n == 0, "R8 no timeout while idle", n, 0);
    chan_busy = 1'b1;
    repeat (10) @(negedge clk);
    chan_busy = 1'b0;
    run_case(1, 0, "R8 count cleared by idle");

    // R7: progress pulses hold off the timeout
    @(negedge clk);
    chan_busy = 1'b1;
    n = 0;
    for (int r = 0; r < 25; r++) begin
      int m;
      chan_progress = 1'b1;
      @(negedge clk);
      chan_progress = 1'b0;
      count_aborts(7, m);
      n += m;
    end
    check(n == 0, "R7 no timeout with progress", n, 0);
    chan_progress = 1'b1;
    run_case(1, 0, "R7 count cleared by progress");

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_vec++;
      n_bad++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

endmodule